// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block couples two parallel data ports, A and B, in both directions. Each direction has its own storage register. On every rising edge of its own clock, that register captures whatever sits on its source port. A per-direction select decides what the far port is offered: the live source data passed straight through, or the stored word. A per-direction drive enable gates the far port's output-enable vector. The A-to-B enable is active high and the B-to-A enable is active low. Each port is split into a resolved input vector, an output vector and an output-enable vector, because the surrounding fabric has no internal tri-state. The pad logic or the bench combines these into a bus.

Each port also has a bus keeper. The keeper is a register that samples the resolved port value on the clock of the direction that reads that port. Loop mode is the case where both directions pass live data and both drives are on. In loop mode each port is fed from the opposite port's keeper, and both keepers stop sampling. The two buses then hold their value with no outside driver, and there is no combinational path from port to port. The two clocks are independent. Reset is asynchronous and active low, and each clock domain releases it through its own synchroniser.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While reset is held, both storage registers read all zeros. With either select at 1 (stored), that direction's output vector is zero.
- R2: On each rising `clk_ab` edge after reset, the A-to-B register captures `a_pad_in`. It does so whatever the values of `sel_ab`, `sel_ba`, `en_ab` and `en_ba_n`.
- R3: On each rising `clk_ba` edge after reset, the B-to-A register captures `b_pad_in`. It does so whatever the values of the selects and enables.
- R4: With `sel_ab` = 1 (stored), `b_pad_out` equals the A-to-B register. A change on `a_pad_in` does not reach it before the next `clk_ab` edge.
- R5: With a select at 0 (live), outside loop mode, the far output follows the source input in the same cycle: `b_pad_out` = `a_pad_in`, or `a_pad_out` = `b_pad_in`.
- R6: `b_pad_oe` is all ones when `en_ab` = 1 and all zeros when `en_ab` = 0.
- R7: `a_pad_oe` is all ones when `en_ba_n` = 0 and all zeros when `en_ba_n` = 1.
- R8: Loop mode is `sel_ab` = 0, `sel_ba` = 0, `en_ab` = 1 and `en_ba_n` = 0. In loop mode, `b_pad_out` presents the A keeper and `a_pad_out` presents the B keeper. Both keepers hold, so both buses keep their value across clock edges with no outside driver.
- R9: Outside loop mode, the A keeper samples `a_pad_in` on every `clk_ab` edge and the B keeper samples `b_pad_in` on every `clk_ba` edge. A later loop mode therefore presents the most recently sampled values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock for the A-to-B register and the A keeper |
| clk_ba | input | 1 | Capture clock for the B-to-A register and the B keeper |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_ab | input | 1 | A-to-B source: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source: 0 live, 1 stored |
| en_ab | input | 1 | Drive enable for port B, active high |
| en_ba_n | input | 1 | Drive enable for port A, active low |
| a_pad_in | input | W | Resolved value of bus A |
| a_pad_out | output | W | Data offered to bus A |
| a_pad_oe | output | W | Per-bit output enable for bus A |
| b_pad_in | input | W | Resolved value of bus B |
| b_pad_out | output | W | Data offered to bus B |
| b_pad_oe | output | W | Per-bit output enable for bus B |

## Verification
Several properties are checked on every edge of the owning clock: that each output-enable vector tracks its enable with the right polarity, that a stored-mode output equals the source port one edge earlier, that live mode passes data straight through, and that both outputs stay stable while loop mode persists. Some behaviour only the bench's directed scenarios can show. These cover the zero state under reset and capture while the drive is disabled, later shown by flipping to stored mode. They also cover the tie between a keeper's last sample and the value that loop mode then holds on both buses once every outside driver has let go. Those scenarios rely on a bench bus model that resolves each bus from the outside driver, the block, or the previous bus value, and that reports any contention.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int XCVR_W = 16;

  typedef enum logic {
    XFER_LIVE   = 1'b0,
    XFER_STORED = 1'b1
  } xfer_sel_e;

  // Loop mode: both directions live and both drives asserted.
  function automatic logic loop_active(input xfer_sel_e s_ab,
                                       input xfer_sel_e s_ba,
                                       input logic drv_ab,
                                       input logic drv_ba);
    return (s_ab == XFER_LIVE) && (s_ba == XFER_LIVE) && drv_ab && drv_ba;
  endfunction

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[LAST];

endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] held
);

  logic [W-1:0] held_q;
  logic [W-1:0] held_d;

  // Next-state: sample the port unless frozen for loop mode.
  always_comb begin
    held_d = held_q;
    if (upd_en) held_d = pad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign held = held_q;

endmodule

// File: rtl/xcvr_dir_path.sv
module xcvr_dir_path
  import xcvr_pkg::*;
#(
  parameter int W      = 16,
  parameter bit EN_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_in,
  input  logic [W-1:0] src_held,
  input  xfer_sel_e    sel,
  input  logic         loop_mode,
  input  logic         en_raw,
  output logic [W-1:0] dst_out,
  output logic [W-1:0] dst_oe
);

  logic         drive;
  logic [W-1:0] stor_q;
  logic [W-1:0] stor_d;
  logic [W-1:0] live_src;

  generate
    if (EN_LOW) begin : g_en_low
      assign drive = ~en_raw;
    end else begin : g_en_high
      assign drive = en_raw;
    end
  endgenerate

  // Capture is independent of select and drive enable.
  always_comb begin
    stor_d = src_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stor_q <= '0;
    else        stor_q <= stor_d;
  end

  // In loop mode the live source is the keeper, breaking the port-to-port path.
  always_comb begin
    live_src = loop_mode ? src_held : src_in;
    dst_out  = (sel == XFER_STORED) ? stor_q : live_src;
    dst_oe   = {W{drive}};
  end

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int W          = XCVR_W,
  parameter int RST_STAGES = 2
) (
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         rst_n,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         en_ab,
  input  logic         en_ba_n,
  input  logic [W-1:0] a_pad_in,
  output logic [W-1:0] a_pad_out,
  output logic [W-1:0] a_pad_oe,
  input  logic [W-1:0] b_pad_in,
  output logic [W-1:0] b_pad_out,
  output logic [W-1:0] b_pad_oe
);

  logic         rst_ab_n;
  logic         rst_ba_n;
  logic         loop_mode;
  logic [W-1:0] a_held;
  logic [W-1:0] b_held;
  xfer_sel_e    sel_ab_e;
  xfer_sel_e    sel_ba_e;

  assign sel_ab_e  = xfer_sel_e'(sel_ab);
  assign sel_ba_e  = xfer_sel_e'(sel_ba);
  assign loop_mode = loop_active(sel_ab_e, sel_ba_e, en_ab, ~en_ba_n);

  xcvr_rst_sync #(.STAGES(RST_STAGES)) u_rst_ab (
    .clk(clk_ab), .arst_n(rst_n), .rst_n_sync(rst_ab_n)
  );

  xcvr_rst_sync #(.STAGES(RST_STAGES)) u_rst_ba (
    .clk(clk_ba), .arst_n(rst_n), .rst_n_sync(rst_ba_n)
  );

  xcvr_keeper #(.W(W)) u_keep_a (
    .clk(clk_ab), .rst_n(rst_ab_n), .upd_en(~loop_mode),
    .pad_in(a_pad_in), .held(a_held)
  );

  xcvr_keeper #(.W(W)) u_keep_b (
    .clk(clk_ba), .rst_n(rst_ba_n), .upd_en(~loop_mode),
    .pad_in(b_pad_in), .held(b_held)
  );

  xcvr_dir_path #(.W(W), .EN_LOW(1'b0)) u_path_ab (
    .clk(clk_ab), .rst_n(rst_ab_n),
    .src_in(a_pad_in), .src_held(a_held),
    .sel(sel_ab_e), .loop_mode(loop_mode), .en_raw(en_ab),
    .dst_out(b_pad_out), .dst_oe(b_pad_oe)
  );

  xcvr_dir_path #(.W(W), .EN_LOW(1'b1)) u_path_ba (
    .clk(clk_ba), .rst_n(rst_ba_n),
    .src_in(b_pad_in), .src_held(b_held),
    .sel(sel_ba_e), .loop_mode(loop_mode), .en_raw(en_ba_n),
    .dst_out(a_pad_out), .dst_oe(a_pad_oe)
  );

endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int W = 16
) (
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         rst_n,
  input logic         rst_ab_n,
  input logic         rst_ba_n,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         en_ab,
  input logic         en_ba_n,
  input logic [W-1:0] a_pad_in,
  input logic [W-1:0] a_pad_out,
  input logic [W-1:0] a_pad_oe,
  input logic [W-1:0] b_pad_in,
  input logic [W-1:0] b_pad_out,
  input logic [W-1:0] b_pad_oe
);

  logic looped;
  assign looped = !sel_ab && !sel_ba && en_ab && !en_ba_n;

  p_reset_zero_r1: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!rst_ab_n && sel_ab) |-> (b_pad_out == '0));

  p_store_ab_r2: assert property (@(posedge clk_ab) disable iff (!rst_ab_n)
    ($past(rst_ab_n) && sel_ab) |-> (b_pad_out == $past(a_pad_in)));

  p_store_ba_r3: assert property (@(posedge clk_ba) disable iff (!rst_ba_n)
    ($past(rst_ba_n) && sel_ba) |-> (a_pad_out == $past(b_pad_in)));

  p_live_ab_r5: assert property (@(posedge clk_ab) disable iff (!rst_ab_n)
    (!sel_ab && !looped) |-> (b_pad_out == a_pad_in));

  p_oe_b_r6: assert property (@(posedge clk_ab) disable iff (!rst_ab_n)
    ($countones(b_pad_oe) == (en_ab ? W : 0)));

  p_oe_a_r7: assert property (@(posedge clk_ba) disable iff (!rst_ba_n)
    ($countones(a_pad_oe) == (en_ba_n ? 0 : W)));

  p_loop_hold_b_r8: assert property (@(posedge clk_ab) disable iff (!rst_ab_n)
    ($past(rst_ab_n) && looped && $past(looped)) |-> $stable(b_pad_out));

  p_loop_hold_a_r8: assert property (@(posedge clk_ba) disable iff (!rst_ba_n)
    ($past(rst_ba_n) && looped && $past(looped)) |-> $stable(a_pad_out));

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W)) u_chk (
  .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
  .rst_ab_n(rst_ab_n), .rst_ba_n(rst_ba_n),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .en_ab(en_ab), .en_ba_n(en_ba_n),
  .a_pad_in(a_pad_in), .a_pad_out(a_pad_out), .a_pad_oe(a_pad_oe),
  .b_pad_in(b_pad_in), .b_pad_out(b_pad_out), .b_pad_oe(b_pad_oe)
);

// File: tb/bus_xcvr_reg_tb.sv
`timescale 1ns/100ps
module bus_xcvr_reg_tb;

  localparam int W = 16;

  logic clk_ab = 1'b0;
  logic clk_ba = 1'b0;
  logic rst_n  = 1'b0;
  logic sel_ab = 1'b1, sel_ba = 1'b1, en_ab = 1'b1, en_ba_n = 1'b0;

  logic [W-1:0] a_ext = '0, b_ext = '0;
  logic         a_ext_en = 1'b0, b_ext_en = 1'b0;
  logic [W-1:0] a_bus = '0, b_bus = '0;
  logic [W-1:0] a_pad_out, a_pad_oe, b_pad_out, b_pad_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_ab = ~clk_ab;
  initial begin
    #1;
    forever #2 clk_ba = ~clk_ba;
  end

  bus_xcvr_reg #(.W(W)) u_dut (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .en_ab(en_ab), .en_ba_n(en_ba_n),
    .a_pad_in(a_bus), .a_pad_out(a_pad_out), .a_pad_oe(a_pad_oe),
    .b_pad_in(b_bus), .b_pad_out(b_pad_out), .b_pad_oe(b_pad_oe)
  );

  // Bus resolution: outside driver, else block driver, else previous value.
  always @* begin
    if (a_ext_en)         a_bus = a_ext;
    else if (a_pad_oe[0]) a_bus = a_pad_out;
  end
  always @* begin
    if (b_ext_en)         b_bus = b_ext;
    else if (b_pad_oe[0]) b_bus = b_pad_out;
  end

  always @(posedge clk_ab) begin
    if (rst_n && a_ext_en && a_pad_oe[0]) begin
      n_chk++; n_bad++;
      $display("FAIL contention on bus A: actual oe=%h expected 0", a_pad_oe);
    end
    if (rst_n && b_ext_en && b_pad_oe[0]) begin
      n_chk++; n_bad++;
      $display("FAIL contention on bus B: actual oe=%h expected 0", b_pad_oe);
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_ab);
  endtask

  task automatic t_reset();
    step(3);
    #1;
    chk("R1 b_pad_out in reset", b_pad_out, '0);
    chk("R1 a_pad_out in reset", a_pad_out, '0);
    step(1);
    rst_n = 1'b1;
    step(4);
  endtask

  task automatic t_store_ab();
    step(1);
    sel_ab = 1'b1; en_ab = 1'b1; en_ba_n = 1'b1; sel_ba = 1'b1;
    a_ext = 16'h1234; a_ext_en = 1'b1; b_ext_en = 1'b0;
    step(1);
    #1; chk("R2 stored capture", b_pad_out, 16'h1234);
    step(1);
    a_ext = 16'h5555;
    #1; chk("R4 stored ignores live A", b_pad_out, 16'h1234);
    chk("R4 bus B keeps stored word", b_bus, 16'h1234);
    step(1);
    #1; chk("R2 next capture", b_pad_out, 16'h5555);
  endtask

  task automatic t_capture_blind();
    step(1);
    en_ab = 1'b0; sel_ab = 1'b0; a_ext = 16'hA5A5;
    #1; chk("R6 b_pad_oe off", b_pad_oe, '0);
    step(1);
    sel_ab = 1'b1; en_ab = 1'b1;
    #1; chk("R2 capture with drive off and live select", b_pad_out, 16'hA5A5);
    chk("R6 b_pad_oe on", b_pad_oe, '1);
  endtask

  task automatic t_store_ba();
    step(1);
    a_ext_en = 1'b0; en_ab = 1'b0; sel_ba = 1'b1; en_ba_n = 1'b0;
    b_ext = 16'hBEEF; b_ext_en = 1'b1;
    step(1);
    #1; chk("R3 stored B-to-A", a_pad_out, 16'hBEEF);
    chk("R7 a_pad_oe on", a_pad_oe, '1);
    chk("R3 bus A carries stored word", a_bus, 16'hBEEF);
    step(1);
    en_ba_n = 1'b1; b_ext = 16'h0F0F;
    #1; chk("R7 a_pad_oe off", a_pad_oe, '0);
    step(1);
    en_ba_n = 1'b0;
    #1; chk("R3 capture with drive off", a_pad_out, 16'h0F0F);
  endtask

  task automatic t_live();
    step(1);
    b_ext_en = 1'b0; en_ba_n = 1'b1; sel_ab = 1'b0; en_ab = 1'b1;
    a_ext = 16'h00FF; a_ext_en = 1'b1;
    #1; chk("R5 live A-to-B", b_pad_out, 16'h00FF);
    step(1);
    a_ext = 16'hFF00;
    #1; chk("R5 live A-to-B same cycle", b_bus, 16'hFF00);
    step(1);
    a_ext_en = 1'b0; en_ab = 1'b0; sel_ba = 1'b0; en_ba_n = 1'b0;
    b_ext = 16'h1357; b_ext_en = 1'b1;
    #1; chk("R5 live B-to-A", a_pad_out, 16'h1357);
  endtask

  task automatic t_loop(input logic [W-1:0] v, input logic [W-1:0] pre);
    step(1);
    b_ext_en = 1'b0; sel_ab = 1'b0; sel_ba = 1'b0; en_ab = 1'b1; en_ba_n = 1'b1;
    a_ext = pre; a_ext_en = 1'b1;
    step(2);
    a_ext = v;
    step(2);
    a_ext_en = 1'b0; en_ba_n = 1'b0;
    #1; chk("R9 keeper tracked last A value", b_pad_out, v);
    chk("R9 keeper tracked last B value", a_pad_out, v);
    step(3);
    #1; chk("R8 loop holds bus A", a_bus, v);
    chk("R8 loop holds bus B", b_bus, v);
    step(1);
    sel_ab = 1'b1;
    #1; chk("R2 capture during loop", b_pad_out, v);
    step(1);
    sel_ab = 1'b0;
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_store_ab();
    t_capture_blind();
    t_store_ba();
    t_live();
    t_loop(16'h3C3C, 16'h0001);
    t_loop(16'hC3C3, 16'h7E7E);
    step(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule